// File: doc/BRIEF.md
# Coincident-Current Core Memory Sequencer

This block sequences accesses to a stack of magnetic-core bit planes, modelled as an abstract array. Each plane stores one bit of the word. The X and Y select lines run through every plane in series, so one address picks one core in each plane. A request carries a direction, an address and a data word. The block splits the address into an X index and a Y index. It then drives one-hot select strobes in two timed phases: a clear phase that forces the addressed cores to zero, and a set phase that writes ones back.

Sensing destroys the stored value. For that reason every access has the same shape. During the clear phase the block gathers the sense lines, one per plane, into a word. On a read it returns that word and restores it in the set phase. On a write it discards that word and stores the new data. A one is never driven directly. The set pulse reaches every plane, and a per-plane inhibit strobe cancels it in each plane whose bit must stay zero. Drive currents and sense thresholds lie outside the block. The environment turns the strobes into pulses and the core output into a logic-level sense input.

Top module: `core_seq`

## Requirements
- R1: The Y index is the low `log2(LINES)` bits of `req_addr` and the X index is the high bits. During a phase, the strobe pair for that phase carries exactly bit X on the X side and bit Y on the Y side (one-hot). Both axes are driven in the same cycles.
- R2: An accepted request first holds `x_clr`/`y_clr` for CLR_CYC cycles. It then waits LAT_CYC cycles and holds `x_set`/`y_set` for SET_CYC cycles. The clear strobes and the set strobes are never active together.
- R3: The read word is bit-wise the OR of `sense` over the clear-phase cycles. Sense activity in any other cycle has no effect on it.
- R4: On a read, `inhibit` during the set phase equals the inverse of the sensed word. The addressed word therefore holds its old value after the read.
- R5: On a write, `inhibit` during the set phase equals the inverse of the write data. The addressed word then holds the write data, and `rd_valid` is not raised.
- R6: `inhibit` is all zero in every cycle in which the set strobes are inactive, including after reset.
- R7: `req_ready` is high only while the sequencer is idle, which includes after reset. A request presented while it is low is ignored and leaves the array unchanged.
- R8: Completion is reported with a one-cycle pulse exactly CLR_CYC+LAT_CYC+SET_CYC+REC_CYC cycles after the accepting edge. Reads raise `rd_valid`, with `rd_data` valid in that cycle. Writes raise `wr_done`. The two pulses are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*log2(LINES) | Word address, {X index, Y index} |
| req_wdata | input | WIDTH | Write data |
| req_ready | output | 1 | Idle, request accepted this cycle |
| x_clr | output | LINES | Clear-direction X strobes, one-hot |
| y_clr | output | LINES | Clear-direction Y strobes, one-hot |
| x_set | output | LINES | Set-direction X strobes, one-hot |
| y_set | output | LINES | Set-direction Y strobes, one-hot |
| inhibit | output | WIDTH | Per-plane set cancel |
| sense | input | WIDTH | Per-plane sense result |
| rd_valid | output | 1 | Read completion pulse |
| rd_data | output | WIDTH | Read word |
| wr_done | output | 1 | Write completion pulse |

## Verification
The main function is exercised with several word patterns:
- All-zero and all-one words test the two extremes of the inhibit mask.
- Alternating words such as A5 and 5A catch swapped or shifted planes.
- A sweep over every address with distinct data catches a swapped X/Y field or a wrong decode index.

Two read patterns target the destructive-read path specifically:
- Reading the same word twice in a row shows whether the restore actually takes place.
- Reading a zero word while the sense lines are held high outside the clear phase separates correct sampling from sampling that is open too wide.

A request pulsed while the sequencer is busy, followed by a read of its target, shows whether busy requests are really dropped.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_CLEAR   = 3'd1,
    PH_LATCH   = 3'd2,
    PH_SET     = 3'd3,
    PH_RECOVER = 3'd4
  } phase_t;
endpackage

// File: rtl/core_phase_ctl.sv
module core_phase_ctl
  import core_seq_pkg::*;
#(
  parameter int CLR_CYC = 2,
  parameter int LAT_CYC = 1,
  parameter int SET_CYC = 2,
  parameter int REC_CYC = 1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_t phase,
  output logic   last
);
  localparam int MAX_A = (CLR_CYC > LAT_CYC) ? CLR_CYC : LAT_CYC;
  localparam int MAX_B = (SET_CYC > REC_CYC) ? SET_CYC : REC_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = (MAXC < 2) ? 1 : $clog2(MAXC);

  logic [CW-1:0] cnt;
  phase_t        nxt;

  function automatic logic [CW-1:0] len_of(phase_t p);
    case (p)
      PH_CLEAR:   len_of = CW'(CLR_CYC - 1);
      PH_LATCH:   len_of = CW'(LAT_CYC - 1);
      PH_SET:     len_of = CW'(SET_CYC - 1);
      PH_RECOVER: len_of = CW'(REC_CYC - 1);
      default:    len_of = '0;
    endcase
  endfunction

  always_comb begin
    case (phase)
      PH_CLEAR:   nxt = PH_LATCH;
      PH_LATCH:   nxt = PH_SET;
      PH_SET:     nxt = PH_RECOVER;
      default:    nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        phase <= PH_CLEAR;
        cnt   <= len_of(PH_CLEAR);
      end
    end else if (cnt == '0) begin
      phase <= nxt;
      cnt   <= len_of(nxt);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (phase != PH_IDLE) && (cnt == '0);
endmodule

// File: rtl/core_sel_decode.sv
module core_sel_decode #(
  parameter  int LINES = 4,
  localparam int LB    = $clog2(LINES)
) (
  input  logic [LB-1:0]    idx,
  output logic [LINES-1:0] hot
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign hot[i] = (idx == LB'(i));
  end
endmodule

// File: rtl/core_plane_path.sv
module core_plane_path
  import core_seq_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  phase_t           phase,
  input  logic             last,
  input  logic             is_wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] sense,
  output logic [WIDTH-1:0] inhibit,
  output logic [WIDTH-1:0] sensed
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_plane
    logic acc_q;
    logic mask_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q  <= 1'b0;
        mask_q <= 1'b0;
      end else begin
        if (start)
          acc_q <= 1'b0;
        else if (phase == PH_CLEAR)
          acc_q <= acc_q | sense[b];
        if (phase == PH_LATCH && last)
          mask_q <= is_wr ? ~wdata[b] : ~acc_q;
      end
    end
    assign inhibit[b] = (phase == PH_SET) && mask_q;
    assign sensed[b]  = acc_q;
  end
endmodule

// File: rtl/core_seq.sv
module core_seq
  import core_seq_pkg::*;
#(
  parameter  int WIDTH   = 8,
  parameter  int LINES   = 4,
  parameter  int CLR_CYC = 2,
  parameter  int LAT_CYC = 1,
  parameter  int SET_CYC = 2,
  parameter  int REC_CYC = 1,
  localparam int LB      = $clog2(LINES),
  localparam int AW      = 2 * LB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [WIDTH-1:0] req_wdata,
  output logic             req_ready,
  output logic [LINES-1:0] x_clr,
  output logic [LINES-1:0] y_clr,
  output logic [LINES-1:0] x_set,
  output logic [LINES-1:0] y_set,
  output logic [WIDTH-1:0] inhibit,
  input  logic [WIDTH-1:0] sense,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic             wr_done
);
  phase_t           phase;
  logic             last;
  logic             start;
  logic             wr_q;
  logic [AW-1:0]    addr_q;
  logic [WIDTH-1:0] wdata_q;
  logic [WIDTH-1:0] sensed;
  logic [LINES-1:0] x_hot, y_hot;
  logic             finish;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;
  assign finish    = (phase == PH_RECOVER) && last;

  core_phase_ctl #(
    .CLR_CYC(CLR_CYC), .LAT_CYC(LAT_CYC), .SET_CYC(SET_CYC), .REC_CYC(REC_CYC)
  ) u_ctl (
    .clk(clk), .rst(rst), .start(start), .phase(phase), .last(last)
  );

  core_sel_decode #(.LINES(LINES)) u_xdec (.idx(addr_q[AW-1:LB]), .hot(x_hot));
  core_sel_decode #(.LINES(LINES)) u_ydec (.idx(addr_q[LB-1:0]),  .hot(y_hot));

  core_plane_path #(.WIDTH(WIDTH)) u_path (
    .clk(clk), .rst(rst), .start(start), .phase(phase), .last(last),
    .is_wr(wr_q), .wdata(wdata_q), .sense(sense),
    .inhibit(inhibit), .sensed(sensed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_valid <= 1'b0;
      wr_done  <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (start) begin
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      rd_valid <= finish && !wr_q;
      wr_done  <= finish && wr_q;
      if (finish && !wr_q)
        rd_data <= sensed;
    end
  end

  assign x_clr = (phase == PH_CLEAR) ? x_hot : '0;
  assign y_clr = (phase == PH_CLEAR) ? y_hot : '0;
  assign x_set = (phase == PH_SET)   ? x_hot : '0;
  assign y_set = (phase == PH_SET)   ? y_hot : '0;
endmodule

// File: rtl/core_seq_chk.sv
module core_seq_chk #(
  parameter int WIDTH = 8,
  parameter int LINES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LINES-1:0] x_clr,
  input logic [LINES-1:0] y_clr,
  input logic [LINES-1:0] x_set,
  input logic [LINES-1:0] y_set,
  input logic [WIDTH-1:0] inhibit,
  input logic             rd_valid,
  input logic             wr_done
);
  AST_ONEHOT_X: assert property (@(posedge clk) disable iff (rst) $onehot0(x_clr | x_set)); // R1
  AST_ONEHOT_Y: assert property (@(posedge clk) disable iff (rst) $onehot0(y_clr | y_set)); // R1
  AST_AXIS_PAIR: assert property (@(posedge clk) disable iff (rst) ((|x_clr) == (|y_clr)) && ((|x_set) == (|y_set))); // R1
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst) !((|x_clr) && (|x_set))); // R2
  AST_INH_IN_SET: assert property (@(posedge clk) disable iff (rst) (|inhibit) |-> (|x_set)); // R6
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> !req_ready); // R7
  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (rst) (rd_valid || wr_done) |-> req_ready); // R7
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst) !(rd_valid && wr_done)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) (rd_valid || wr_done) |=> !(rd_valid || wr_done)); // R8
endmodule

bind core_seq core_seq_chk #(.WIDTH(WIDTH), .LINES(LINES)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .x_clr(x_clr), .y_clr(y_clr), .x_set(x_set), .y_set(y_set),
  .inhibit(inhibit), .rd_valid(rd_valid), .wr_done(wr_done)
);

// File: tb/core_seq_test.sv
module core_seq_test;
  localparam int PERIOD = 10;
  localparam int W      = 8;
  localparam int N      = 4;
  localparam int LB     = 2;
  localparam int AW     = 4;
  localparam int WORDS  = 16;
  localparam int LAT    = 2 + 1 + 2 + 1;

  logic clk = 0;
  logic rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [W-1:0]  req_wdata = '0;
  logic req_ready, rd_valid, wr_done;
  logic [N-1:0] x_clr, y_clr, x_set, y_set;
  logic [W-1:0] inhibit, sense, rd_data;

  always #(PERIOD/2) clk = ~clk;

  core_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .x_clr(x_clr), .y_clr(y_clr), .x_set(x_set), .y_set(y_set),
    .inhibit(inhibit), .sense(sense), .rd_valid(rd_valid),
    .rd_data(rd_data), .wr_done(wr_done)
  );

  // behavioural core stack
  logic [W-1:0] cores [WORDS];
  logic [W-1:0] ref_mem [WORDS];
  logic noise = 0;

  function automatic int hot_idx(logic [N-1:0] v);
    int r = 0;
    for (int i = 0; i < N; i++) if (v[i]) r = i;
    return r;
  endfunction

  assign sense = (|x_clr && |y_clr) ? cores[hot_idx(x_clr)*N + hot_idx(y_clr)]
                                    : (noise ? '1 : '0);

  always @(posedge clk) begin
    if (|x_clr && |y_clr)
      cores[hot_idx(x_clr)*N + hot_idx(y_clr)] <= '0;
    else if (|x_set && |y_set)
      cores[hot_idx(x_set)*N + hot_idx(y_set)] <=
        cores[hot_idx(x_set)*N + hot_idx(y_set)] | ~inhibit;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, fails = 0;
  bit done_all = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard
  bit           q_wr   [$];
  logic [W-1:0] q_data [$];
  int           acc_cyc;
  logic [AW-1:0] cur_addr;
  logic [W-1:0]  exp_inh;
  bit dec_seen, inh_seen;

  always @(negedge clk) begin
    if (!rst) begin
      if (|x_clr && !dec_seen) begin
        dec_seen = 1;
        chk(x_clr == N'(1 << cur_addr[AW-1:LB]), "R1", "x_clr", x_clr, N'(1 << cur_addr[AW-1:LB]));
        chk(y_clr == N'(1 << cur_addr[LB-1:0]), "R1", "y_clr", y_clr, N'(1 << cur_addr[LB-1:0]));
      end
      if (|x_set && !inh_seen) begin
        inh_seen = 1;
        chk(inhibit == exp_inh, "R4/R5", "inhibit in set", inhibit, exp_inh);
        chk(x_set == x_hot_exp() && y_set == N'(1 << cur_addr[LB-1:0]), "R1", "set strobes", {x_set, y_set},
            {x_hot_exp(), N'(1 << cur_addr[LB-1:0])});
      end
      if (!(|x_set))
        chk(inhibit == '0, "R6", "inhibit outside set", inhibit, 0);
      if (rd_valid || wr_done) begin
        if (q_wr.size() == 0) begin
          chk(0, "R8", "unexpected completion", {rd_valid, wr_done}, 0);
        end else begin
          bit wr;
          logic [W-1:0] d;
          wr = q_wr.pop_front();
          d  = q_data.pop_front();
          chk(cyc - acc_cyc == LAT, "R8", "latency", cyc - acc_cyc, LAT);
          chk(wr_done == wr && rd_valid == !wr, wr ? "R5" : "R8", "completion kind",
              {rd_valid, wr_done}, {!wr, wr});
          if (!wr) chk(rd_data == d, "R3", "read data", rd_data, d);
          chk(cores[cur_addr] == ref_mem[cur_addr], wr ? "R5" : "R4", "stored word",
              cores[cur_addr], ref_mem[cur_addr]);
        end
      end
    end
  end

  function automatic logic [N-1:0] x_hot_exp();
    return N'(1 << cur_addr[AW-1:LB]);
  endfunction

  task automatic do_op(bit wr, int addr, logic [W-1:0] data, bit poke = 0);
    while (!req_ready) @(negedge clk);
    cur_addr = AW'(addr);
    dec_seen = 0;
    inh_seen = 0;
    exp_inh  = wr ? ~data : ~ref_mem[addr];
    q_wr.push_back(wr);
    q_data.push_back(wr ? data : ref_mem[addr]);
    if (wr) ref_mem[addr] = data;
    req_valid = 1; req_write = wr; req_addr = AW'(addr); req_wdata = data;
    @(posedge clk); #1 acc_cyc = cyc;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      // busy: this request must be dropped (R7)
      chk(req_ready == 0, "R7", "ready while busy", req_ready, 0);
      req_valid = 1; req_write = 1; req_addr = AW'(5); req_wdata = 8'h33;
      @(negedge clk);
      req_valid = 0;
    end
    while (q_wr.size() != 0) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done_all) begin
      done_all = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    chk(0, "R8", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin cores[i] = '0; ref_mem[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1, "R7", "ready after reset", req_ready, 1);
    chk({x_clr, y_clr, x_set, y_set} == '0, "R2", "strobes after reset", {x_clr, y_clr, x_set, y_set}, 0);
    chk(inhibit == '0, "R6", "inhibit after reset", inhibit, 0);
    chk(rd_valid == 0 && wr_done == 0, "R8", "no completion after reset", {rd_valid, wr_done}, 0);

    do_op(1, 0, 8'hA5);
    do_op(1, 15, 8'h5A);
    do_op(1, 5, 8'hFF);
    do_op(1, 10, 8'h00);
    do_op(1, 3, 8'h81);
    do_op(0, 0, 0);
    do_op(0, 15, 0);
    do_op(0, 5, 0);
    do_op(0, 10, 0);
    do_op(0, 3, 0);
    do_op(0, 0, 0);   // second read: restore check R4
    noise = 1;        // sense high outside clear phase (R3)
    do_op(0, 10, 0);
    do_op(0, 5, 0);
    noise = 0;
    do_op(0, 3, 0, 1);  // R7 busy poke at address 5
    do_op(0, 5, 0);     // must still read FF
    for (int a = 0; a < WORDS; a++) do_op(1, a, W'((a * 17) ^ 8'h3C));
    for (int a = 0; a < WORDS; a++) do_op(0, a, 0);
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule